// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a small data cache that sits between a processor request port and a slower block-wide memory port. The address is split into three fields. The low bits pick a byte inside a block. The middle bits pick a set. The upper bits form the tag. Every way of the chosen set is compared at the same time, and a way hits when its valid bit is set and its stored tag equals the request tag. A hit on a read returns the addressed byte in the same cycle. A hit on a write changes only the cached byte and marks the line dirty.

On a miss the block picks a victim way in the set. If the victim line is dirty, the whole block is first copied back to memory. The requested block is then fetched, and the request is replayed, now as a hit. By default the victim is chosen with small per-line recency counters, which approximate least-recently-used. A parameter swaps this for a free-running LFSR. The processor holds its request steady until the cache signals ready.

Top module: `cache_sa_top`

## Requirements
- R1: After reset every line is invalid and clean, and every recency counter is zero. While the reset is applied and with no request, `cpu_ready` and `mem_req` are low. The first access to any address is therefore a miss.
- R2: With the default parameters, `cpu_addr[0]` is the byte offset, `cpu_addr[2:1]` is the set and `cpu_addr[7:3]` is the tag. A way hits only when its valid bit is 1 and its tag is equal to the request tag, and at most one way of a set hits.
- R3: On a read hit, `cpu_ready` is high in the same cycle the request is presented. `cpu_rdata` is the byte picked by the offset: offset 0 gives block bits 7:0 and offset 1 gives bits 15:8.
- R4: On a miss, `cpu_ready` is low in the first cycle. Exactly one refill of block address `cpu_addr[7:1]` takes place. `cpu_ready` rises in the first cycle after the refill acknowledge, with the fetched data.
- R5: A write hit changes only the addressed byte in the cache and sets the line's dirty bit. It starts no memory transfer.
- R6: The victim is the lowest-numbered invalid way of the set. If the set has no invalid way, the victim is the way with the largest recency value, and the lowest index wins a tie.
- R7: On every hit, including the replayed hit after a refill, the accessed way's counter becomes 0. Every other way in the set whose counter is less than or equal to the accessed way's old value, and below WAYS-1, increments by one.
- R8: A dirty victim is written back as one whole block to block address {victim tag, set} before the refill starts. A clean victim is replaced with no memory write.
- R9: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` held stable, until a one-cycle `mem_ack` arrives. Each transfer moves one whole block. In a block, byte 0 is bits 7:0.
- R10: With `RANDOM_REPL=1`, the victim in a set with no invalid way comes from the low bits of an 8-bit LFSR. Invalid ways are still used first, and reads still return the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 for a byte write, 0 for a byte read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid while ready is high |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a block write-back, 0 for a refill |
| mem_addr | output | ADDR_W-OFF_W | Block address |
| mem_wdata | output | 8<<OFF_W | Write-back block |
| mem_rdata | input | 8<<OFF_W | Refill block, valid with ack |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
The directed part of the bench fills both ways of one set and then touches way 0 again. It forces a third tag into the set, and only way 1 must be evicted. A design that ignored recency, or that took any invalid way before a valid one, would evict the wrong line, and the next access would show a hit or miss the reference did not expect. A write hit followed by an eviction of that line must produce exactly one write-back, carrying the written byte. A design that lost the dirty bit would skip the write-back, and a design that refilled before the write-back would return stale data on re-read. A random mix of reads and writes over eight tags keeps sets under pressure, and it compares every read byte, the ready timing, the refill count and the write-back address and payload with a reference model. A second instance with random replacement has to keep returning correct data.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRBACK = 2'd1,
        ST_REFILL = 2'd2
    } cache_state_e;

    localparam int LFSR_W = 8;

endpackage

// File: rtl/cache_way_match.sv
module cache_way_match #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1,
    parameter int TAG_W = 5
) (
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic [WAYS-1:0]            hit_vec_o,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           hit_way_o
);

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_cmp
            assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == tag_i);
        end
    endgenerate

    assign hit_o = |hit_vec_o;

    always_comb begin
        hit_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec_o[w]) begin
                hit_way_o = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/cache_recency_update.sv
module cache_recency_update #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1,
    parameter int AGE_W = 1
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_i,
    input  logic [WAY_W-1:0]           use_way_i,
    output logic [WAYS-1:0][AGE_W-1:0] age_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

    logic [AGE_W-1:0] ref_age;

    always_comb begin
        ref_age = age_i[use_way_i];
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == use_way_i) begin
                age_o[w] = '0;
            end else if ((age_i[w] <= ref_age) && (age_i[w] != AGE_MAX)) begin
                age_o[w] = age_i[w] + 1'b1;
            end else begin
                age_o[w] = age_i[w];
            end
        end
    end

endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick
    import cache_pkg::*;
#(
    parameter int WAYS        = 2,
    parameter int WAY_W       = 1,
    parameter int AGE_W       = 1,
    parameter bit RANDOM_REPL = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][AGE_W-1:0] age_i,
    output logic [WAY_W-1:0]           victim_o
);

    logic [WAY_W-1:0] full_pick;

    generate
        if (RANDOM_REPL) begin : g_rand
            logic [LFSR_W-1:0] lfsr_d, lfsr_q;
            always_comb begin
                lfsr_d = {lfsr_q[LFSR_W-2:0],
                          lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
            end
            always_ff @(posedge clk) begin
                if (!rst_n) lfsr_q <= LFSR_W'(1);
                else        lfsr_q <= lfsr_d;
            end
            assign full_pick = lfsr_q[WAY_W-1:0];
            logic unused_age;
            assign unused_age = ^age_i;
        end else begin : g_age
            logic [AGE_W-1:0] best_age;
            always_comb begin
                full_pick = '0;
                best_age  = age_i[0];
                for (int w = 1; w < WAYS; w++) begin
                    if (age_i[w] > best_age) begin
                        best_age  = age_i[w];
                        full_pick = WAY_W'(w);
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        victim_o = full_pick;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                victim_o = WAY_W'(w);
            end
        end
    end

    AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&valid_i)) |-> !valid_i[victim_o]); // R6

endmodule

// File: rtl/cache_sa_top.sv
module cache_sa_top
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int LINE_W      = 3,
    parameter int WAY_W       = 1,
    parameter int OFF_W       = 1,
    parameter bit RANDOM_REPL = 1'b0,
    localparam int BADDR_W    = ADDR_W - OFF_W,
    localparam int BLK_W      = 8 << OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [7:0]         cpu_wdata,
    output logic [7:0]         cpu_rdata,
    output logic               cpu_ready,
    output logic               mem_req,
    output logic               mem_we,
    output logic [BADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]   mem_wdata,
    input  logic [BLK_W-1:0]   mem_rdata,
    input  logic               mem_ack
);

    localparam int WAYS  = 1 << WAY_W;
    localparam int LINES = 1 << LINE_W;
    localparam int SET_W = LINE_W - WAY_W;
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam int AGE_W = WAY_W;

    typedef struct packed {
        cache_state_e                   st;
        logic [WAY_W-1:0]               vway;
        logic [LINES-1:0]               valid;
        logic [LINES-1:0]               dirty;
        logic [LINES-1:0][TAG_W-1:0]    tag;
        logic [LINES-1:0][BLK_W-1:0]    data;
        logic [LINES-1:0][AGE_W-1:0]    age;
    } cache_rec_t;

    cache_rec_t s_d, s_q;

    logic [OFF_W-1:0]             off_f;
    logic [SET_W-1:0]             set_f;
    logic [TAG_W-1:0]             tag_f;
    logic [WAYS-1:0]              set_valid;
    logic [WAYS-1:0][TAG_W-1:0]   set_tag;
    logic [WAYS-1:0][AGE_W-1:0]   set_age;
    logic [WAYS-1:0][AGE_W-1:0]   set_age_new;
    logic [WAYS-1:0]              hit_vec;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             victim;
    logic [LINE_W-1:0]            hline;
    logic [LINE_W-1:0]            vline;
    logic [LINE_W-1:0]            nline;

    assign off_f = cpu_addr[OFF_W-1:0];
    assign set_f = cpu_addr[OFF_W +: SET_W];
    assign tag_f = cpu_addr[ADDR_W-1 -: TAG_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_valid[w] = s_q.valid[{set_f, WAY_W'(w)}];
            set_tag[w]   = s_q.tag[{set_f, WAY_W'(w)}];
            set_age[w]   = s_q.age[{set_f, WAY_W'(w)}];
        end
    end

    cache_way_match #(
        .WAYS (WAYS),
        .WAY_W(WAY_W),
        .TAG_W(TAG_W)
    ) u_match (
        .valid_i  (set_valid),
        .tags_i   (set_tag),
        .tag_i    (tag_f),
        .hit_vec_o(hit_vec),
        .hit_o    (hit),
        .hit_way_o(hit_way)
    );

    cache_recency_update #(
        .WAYS (WAYS),
        .WAY_W(WAY_W),
        .AGE_W(AGE_W)
    ) u_recency (
        .age_i    (set_age),
        .use_way_i(hit_way),
        .age_o    (set_age_new)
    );

    cache_victim_pick #(
        .WAYS       (WAYS),
        .WAY_W      (WAY_W),
        .AGE_W      (AGE_W),
        .RANDOM_REPL(RANDOM_REPL)
    ) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (set_valid),
        .age_i   (set_age),
        .victim_o(victim)
    );

    assign hline = {set_f, hit_way};
    assign vline = {set_f, s_q.vway};
    assign nline = {set_f, victim};

    assign cpu_rdata = s_q.data[hline][{off_f, 3'b000} +: 8];
    assign mem_wdata = s_q.data[vline];

    always_comb begin
        s_d       = s_q;
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cpu_addr[ADDR_W-1:OFF_W];
        unique case (s_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        cpu_ready = 1'b1;
                        for (int w = 0; w < WAYS; w++) begin
                            s_d.age[{set_f, WAY_W'(w)}] = set_age_new[w];
                        end
                        if (cpu_we) begin
                            s_d.data[hline][{off_f, 3'b000} +: 8] = cpu_wdata;
                            s_d.dirty[hline] = 1'b1;
                        end
                    end else begin
                        s_d.vway = victim;
                        if (s_q.valid[nline] && s_q.dirty[nline]) begin
                            s_d.st = ST_WRBACK;
                        end else begin
                            s_d.st = ST_REFILL;
                        end
                    end
                end
            end
            ST_WRBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {s_q.tag[vline], set_f};
                if (mem_ack) begin
                    s_d.dirty[vline] = 1'b0;
                    s_d.st           = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_d.valid[vline] = 1'b1;
                    s_d.dirty[vline] = 1'b0;
                    s_d.tag[vline]   = tag_f;
                    s_d.data[vline]  = mem_rdata;
                    s_d.st           = ST_IDLE;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> $onehot0(hit_vec)); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R8

    AST_READY_QUIET_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req); // R5

    AST_REPLAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && cpu_req) |=> cpu_ready); // R4

endmodule

// File: tb/tb_cache_sa_top.sv
module tb_cache_sa_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [6:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    logic        r_req = 1'b0;
    logic [7:0]  r_addr = '0;
    logic [7:0]  r_rdata;
    logic        r_ready, r_mem_req, r_mem_we;
    logic [6:0]  r_mem_addr;
    logic [15:0] r_mem_wdata;
    logic [15:0] r_mem_rdata = '0;
    logic        r_mem_ack = 1'b0;

    always #5 clk = ~clk;

    cache_sa_top dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    cache_sa_top #(.RANDOM_REPL(1'b1)) dut_rnd (
        .clk(clk), .rst_n(rst_n), .cpu_req(r_req), .cpu_we(1'b0),
        .cpu_addr(r_addr), .cpu_wdata(8'h00), .cpu_rdata(r_rdata),
        .cpu_ready(r_ready), .mem_req(r_mem_req), .mem_we(r_mem_we),
        .mem_addr(r_mem_addr), .mem_wdata(r_mem_wdata), .mem_rdata(r_mem_rdata),
        .mem_ack(r_mem_ack)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] bmem   [256];
    logic [7:0] golden [256];
    int         wb_cnt = 0, rf_cnt = 0;
    logic [6:0] wb_last = '0;

    bit         m_valid [8];
    bit         m_dirty [8];
    logic [4:0] m_tag   [8];
    int         m_age   [8];

    function automatic logic [7:0] init_byte(input int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // main memory responder: ack after three request cycles, one-cycle pulse
    initial begin
        int lat;
        logic [6:0] held;
        lat = 0;
        held = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                lat++;
                if (lat == 1) held = mem_addr;
                if (lat >= 3) begin
                    lat = 0;
                    chk(mem_addr == held, "R9 address held until ack", int'(mem_addr), int'(held));
                    if (mem_we) begin
                        bmem[{mem_addr, 1'b0}] = mem_wdata[7:0];
                        bmem[{mem_addr, 1'b1}] = mem_wdata[15:8];
                        wb_cnt++;
                        wb_last = mem_addr;
                    end else begin
                        mem_rdata = {bmem[{mem_addr, 1'b1}], bmem[{mem_addr, 1'b0}]};
                        rf_cnt++;
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    // responder for the random-replacement instance: fixed contents, quick ack
    initial begin
        forever begin
            @(negedge clk);
            if (r_mem_ack) begin
                r_mem_ack = 1'b0;
            end else if (r_mem_req) begin
                r_mem_rdata = {init_byte({r_mem_addr, 1'b1}), init_byte({r_mem_addr, 1'b0})};
                r_mem_ack = 1'b1;
            end
        end
    end

    task automatic touch(input int s, input int way);
        int old;
        old = m_age[s*2 + way];
        for (int w = 0; w < 2; w++) begin
            if (w != way && m_age[s*2 + w] <= old && m_age[s*2 + w] != 1)
                m_age[s*2 + w]++;
        end
        m_age[s*2 + way] = 0;
    endtask

    task automatic access(input bit we, input logic [7:0] a, input logic [7:0] wd);
        int s, hw, vw, n, wb0, rf0, bb;
        bit exp_hit, exp_wb;
        logic [6:0] wb_blk;
        logic [4:0] t;
        s = int'(a[2:1]);
        t = a[7:3];
        hw = -1;
        for (int w = 0; w < 2; w++)
            if (m_valid[s*2 + w] && m_tag[s*2 + w] == t) hw = w;
        exp_hit = (hw >= 0);
        exp_wb = 0;
        wb_blk = '0;
        if (!exp_hit) begin
            vw = -1;
            for (int w = 1; w >= 0; w--)
                if (!m_valid[s*2 + w]) vw = w;
            if (vw < 0) vw = (m_age[s*2 + 1] > m_age[s*2]) ? 1 : 0;
            if (m_valid[s*2 + vw] && m_dirty[s*2 + vw]) begin
                exp_wb = 1;
                wb_blk = {m_tag[s*2 + vw], 2'(s)};
            end
            m_valid[s*2 + vw] = 1;
            m_dirty[s*2 + vw] = 0;
            m_tag[s*2 + vw]   = t;
            hw = vw;
        end
        touch(s, hw);
        if (we) m_dirty[s*2 + hw] = 1;

        wb0 = wb_cnt;
        rf0 = rf_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        if (exp_hit) chk(cpu_ready == 1'b1, "R3 hit ready in first cycle", int'(cpu_ready), 1);
        else         chk(cpu_ready == 1'b0, "R4 miss not ready in first cycle", int'(cpu_ready), 0);
        n = 0;
        while (!cpu_ready && n < 1000) begin
            @(negedge clk);
            #1;
            n++;
        end
        if (!we) chk(cpu_rdata == golden[a], "R3 read byte", int'(cpu_rdata), int'(golden[a]));
        else     golden[a] = wd;
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        chk(rf_cnt - rf0 == (exp_hit ? 0 : 1), "R4 refill count", rf_cnt - rf0, exp_hit ? 0 : 1);
        chk(wb_cnt - wb0 == int'(exp_wb), "R8 write-back count", wb_cnt - wb0, int'(exp_wb));
        if (exp_wb) begin
            bb = int'({wb_blk, 1'b0});
            chk(wb_last == wb_blk, "R8 write-back block address", int'(wb_last), int'(wb_blk));
            chk({bmem[bb+1], bmem[bb]} == {golden[bb+1], golden[bb]}, "R8 write-back payload",
                int'({bmem[bb+1], bmem[bb]}), int'({golden[bb+1], golden[bb]}));
        end
        if (we && exp_hit)
            chk((rf_cnt == rf0) && (wb_cnt == wb0), "R5 write hit makes no transfer", rf_cnt - rf0, 0);
    endtask

    task automatic raccess(input logic [7:0] a);
        int n;
        @(negedge clk);
        r_req = 1'b1; r_addr = a;
        #1;
        n = 0;
        while (!r_ready && n < 100) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(r_ready && r_rdata == init_byte(int'(a)), "R10 random-replacement read byte",
            int'(r_rdata), int'(init_byte(int'(a))));
        @(posedge clk);
        #1;
        r_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R4: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1337));
        for (int i = 0; i < 256; i++) begin
            bmem[i]   = init_byte(i);
            golden[i] = init_byte(i);
        end
        for (int i = 0; i < 8; i++) begin
            m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; m_age[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0, "R1 ready low in reset", int'(cpu_ready), 0);
        chk(mem_req == 1'b0, "R1 mem_req low in reset", int'(mem_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1 idle after reset", int'(mem_req), 0);

        // directed: set 0, offsets, ways, recency and dirty eviction
        access(0, 8'h00, 8'h00);   // R1 cold miss, fills way 0
        access(0, 8'h01, 8'h00);   // R2 R3 offset 1 on hit
        access(0, 8'h08, 8'h00);   // R6 invalid way 1 taken
        access(0, 8'h00, 8'h00);   // R7 way 0 made most recent
        access(0, 8'h10, 8'h00);   // R6 R7 evicts way 1, clean
        access(0, 8'h00, 8'h00);   // R6 way 0 kept
        access(1, 8'h11, 8'h3C);   // R5 write hit, dirty
        access(0, 8'h00, 8'h00);
        access(0, 8'h18, 8'h00);   // R8 dirty way evicted, written back
        access(0, 8'h11, 8'h00);   // R8 re-read returns written byte
        access(1, 8'hFE, 8'h77);   // R4 write miss then replay
        access(0, 8'hFF, 8'h00);

        // random mix over eight tags
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            a = 8'($urandom % 64);
            access(($urandom % 3) == 0, a, 8'($urandom));
        end

        // random-replacement instance
        for (int i = 0; i < 120; i++) raccess(8'($urandom % 64));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule